// File: doc/BRIEF.md
# Hot-Plug Slot Command Controller

This block manages a small set of hot-plug slots on behalf of system software. Software writes a target slot number and then a one-byte command code. One cycle later the controller runs the command. A slot command changes that slot's 2-bit state field, its power indicator and its attention indicator. A bulk command acts on every slot at once. A mode command selects the secondary bus speed. The controller records the outcome in a 4-bit command status word and raises a sticky command-done flag.

Each slot starts from a per-slot occupancy input. A slot that holds a card comes out of reset enabled, with its power indicator on. An empty slot comes out of reset disabled, with its latch open. A slot can move into the off condition, meaning state disabled with the power indicator off. When it does, the controller marks the slot's latch open and its presence as empty, and it latches a presence-change event and a latch-change event for software.

The register port is a plain write strobe with a 2-bit select and no back-pressure. Every write is accepted in the cycle it is presented. The select values are 0 for the command code, 1 for the target, 2 for interrupt control and 3 for event clear.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, an occupied slot reads state enabled (2) with its power indicator on (1). An empty slot reads state disabled (3) with its power indicator off (3). Every attention indicator reads off (3). Latch-open equals the inverse of occupancy. Presence reads 00 for an occupied slot and 11 for an empty one. The command status and the done flag read 0.
- R2: Codes 0x00 to 0x3F are slot commands. Bits [1:0] give the new state (0 keep, 1 power only, 2 enabled, 3 disabled). Bits [3:2] give the power indicator and bits [5:4] the attention indicator (0 keep, 1 on, 2 blink, 3 off). A field of 0 leaves that field unchanged.
- R3: A slot command whose target is 0 or greater than NSLOTS sets invalid-command (status bit 2) and changes no slot.
- R4: A request for power only on a slot that is enabled sets invalid-command and leaves the slot unchanged.
- R5: Codes 0x40 to 0x47 select bus mode code[2:0]. Mode 0 completes with a clean status. Any other mode sets invalid-mode (status bit 3).
- R6: If any slot is enabled, code 0x48 (power all) or 0x49 (enable all) sets invalid-command and changes no slot.
- R7: When bulk code 0x48 or 0x49 is accepted, every slot with a closed latch takes power only or enabled, respectively, with its power indicator on. Every slot with an open latch gets its power indicator off and keeps its state.
- R8: Any code outside the ranges and values above sets invalid-command.
- R9: Each new command clears all four status bits before recording its own result. Status bits 0 (busy) and 1 (latch open) always read 0.
- R10: Every command, whether it succeeds or fails, sets the done flag. A write to the interrupt-control select with data bit 16 set clears the flag. A write with bit 16 clear leaves it set.
- R11: A slot that moves from not-off to off sets its latch-open bit, sets its presence to 11, and sets both of its event bits.
- R12: Only data bits [4:0] of a target write are stored.
- R13: A write to the event-clear select clears both event bits of every slot i whose data bit i is 1. Other slots keep their events.
- R14: A command takes effect on the clock edge that follows the edge which captures the code write. The status, the done flag and the slots are unchanged until that second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 code, 1 target, 2 interrupt control, 3 event clear |
| reg_wdata | input | 32 | Write data |
| slot_occupied | input | NSLOTS | Per-slot card present, sampled during reset |
| cmd_status | output | 4 | {invalid mode, invalid command, latch open, busy} |
| cmd_detected | output | 1 | Sticky command-done flag |
| slot_state | output | 2*NSLOTS | State of slot i at [2i+1:2i] |
| slot_pwr_ind | output | 2*NSLOTS | Power indicator of slot i |
| slot_attn_ind | output | 2*NSLOTS | Attention indicator of slot i |
| slot_latch_open | output | NSLOTS | Latch-open status per slot |
| slot_presence | output | 2*NSLOTS | Presence field per slot (11 = empty) |
| slot_ev_presence | output | NSLOTS | Latched presence-change event |
| slot_ev_latch | output | NSLOTS | Latched latch-change event |

## Verification
The assertions assume that slot_occupied holds steady through reset and that a slot is never the target of a single-slot command and a bulk command in the same cycle. They also assume that no new command is written while the previous one is still pending. The stimulus meets these assumptions by driving occupancy only while reset is asserted. It also separates every code write from the next by at least one idle cycle, and it changes inputs only on falling edges.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  typedef enum logic [1:0] {ST_KEEP = 2'd0, ST_PWRONLY = 2'd1, ST_ENABLED = 2'd2, ST_DISABLED = 2'd3} slot_st_e;
  typedef enum logic [1:0] {IND_KEEP = 2'd0, IND_ON = 2'd1, IND_BLINK = 2'd2, IND_OFF = 2'd3} ind_e;
  typedef enum logic [2:0] {OP_SLOT, OP_MODE, OP_PWR_ALL, OP_EN_ALL, OP_BAD} op_e;

  typedef struct packed {
    op_e        op;
    slot_st_e   st;
    ind_e       pwr;
    ind_e       attn;
    logic [2:0] mode;
  } cmd_fields_t;

  localparam int TGT_BITS = 5;
  localparam logic [1:0] SEL_CODE  = 2'd0;
  localparam logic [1:0] SEL_TGT   = 2'd1;
  localparam logic [1:0] SEL_INT   = 2'd2;
  localparam logic [1:0] SEL_EVCLR = 2'd3;
  localparam int DONE_CLR_BIT = 16;
endpackage

// File: rtl/hpc_decode.sv
module hpc_decode import hpc_pkg::*; (
  input  logic [7:0]  code,
  output cmd_fields_t fields
);
  always_comb begin
    fields.st   = slot_st_e'(code[1:0]);
    fields.pwr  = ind_e'(code[3:2]);
    fields.attn = ind_e'(code[5:4]);
    fields.mode = code[2:0];
    if (code[7:6] == 2'b00)          fields.op = OP_SLOT;
    else if (code[7:3] == 5'b01000)  fields.op = OP_MODE;
    else if (code == 8'h48)          fields.op = OP_PWR_ALL;
    else if (code == 8'h49)          fields.op = OP_EN_ALL;
    else                             fields.op = OP_BAD;
  end
endmodule

// File: rtl/hpc_slot.sv
module hpc_slot import hpc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       occupied,
  input  logic       hit,
  input  logic       bulk_go,
  input  slot_st_e   bulk_st,
  input  slot_st_e   req_st,
  input  ind_e       req_pwr,
  input  ind_e       req_attn,
  input  logic       ev_clr,
  output slot_st_e   state,
  output ind_e       pwr,
  output ind_e       attn,
  output logic       latch_open,
  output logic [1:0] presence,
  output logic       ev_presence,
  output logic       ev_latch
);
  slot_st_e want_st, nxt_st;
  ind_e     want_pwr, want_attn, nxt_pwr, nxt_attn;
  logic     go, off_now, off_nxt, drop;

  always_comb begin
    want_st   = ST_KEEP;
    want_pwr  = IND_KEEP;
    want_attn = IND_KEEP;
    if (hit) begin
      want_st   = req_st;
      want_pwr  = req_pwr;
      want_attn = req_attn;
    end else if (bulk_go) begin
      if (latch_open) begin
        want_pwr = IND_OFF;
      end else begin
        want_st  = bulk_st;
        want_pwr = IND_ON;
      end
    end
    nxt_st   = (want_st   == ST_KEEP)  ? state : want_st;
    nxt_pwr  = (want_pwr  == IND_KEEP) ? pwr   : want_pwr;
    nxt_attn = (want_attn == IND_KEEP) ? attn  : want_attn;
    go       = hit || bulk_go;
    off_now  = (state == ST_DISABLED) && (pwr == IND_OFF);
    off_nxt  = (nxt_st == ST_DISABLED) && (nxt_pwr == IND_OFF);
    drop     = go && !off_now && off_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= occupied ? ST_ENABLED : ST_DISABLED;
      pwr         <= occupied ? IND_ON : IND_OFF;
      attn        <= IND_OFF;
      latch_open  <= !occupied;
      presence    <= occupied ? 2'b00 : 2'b11;
      ev_presence <= 1'b0;
      ev_latch    <= 1'b0;
    end else begin
      if (go) begin
        state <= nxt_st;
        pwr   <= nxt_pwr;
        attn  <= nxt_attn;
      end
      if (ev_clr) begin
        ev_presence <= 1'b0;
        ev_latch    <= 1'b0;
      end
      if (drop) begin
        latch_open  <= 1'b1;
        presence    <= 2'b11;
        ev_presence <= 1'b1;
        ev_latch    <= 1'b1;
      end
    end
  end

  // R2: without a command aimed at it, a slot keeps all three fields
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit || bulk_go) |=> ($stable(state) && $stable(pwr) && $stable(attn)));

  // R11: entering the off condition marks latch open, empty and both events
  p_off_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DISABLED) && (pwr == IND_OFF) &&
     !($past(state) == ST_DISABLED && $past(pwr) == IND_OFF))
    |-> (latch_open && presence == 2'b11 && ev_presence && ev_latch));

  // R6: single and bulk commands never reach a slot together
  p_one_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && bulk_go));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl import hpc_pkg::*; #(
  parameter int NSLOTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [1:0]            reg_sel,
  input  logic [31:0]           reg_wdata,
  input  logic [NSLOTS-1:0]     slot_occupied,
  output logic [3:0]            cmd_status,
  output logic                  cmd_detected,
  output logic [2*NSLOTS-1:0]   slot_state,
  output logic [2*NSLOTS-1:0]   slot_pwr_ind,
  output logic [2*NSLOTS-1:0]   slot_attn_ind,
  output logic [NSLOTS-1:0]     slot_latch_open,
  output logic [2*NSLOTS-1:0]   slot_presence,
  output logic [NSLOTS-1:0]     slot_ev_presence,
  output logic [NSLOTS-1:0]     slot_ev_latch
);
  logic [7:0]          code_q;
  logic [TGT_BITS-1:0] tgt_q;
  logic                pend;
  cmd_fields_t         f;
  slot_st_e            st_w [NSLOTS];
  ind_e                pw_w [NSLOTS];
  ind_e                at_w [NSLOTS];
  logic [NSLOTS-1:0]   en_vec;
  slot_st_e            cur_st, bulk_st;
  logic                tgt_ok, any_en, inv_cmd, inv_mode, single_go, bulk_go;
  logic                wdata_unused;

  assign wdata_unused = ^reg_wdata;

  hpc_decode u_dec (.code(code_q), .fields(f));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q       <= '0;
      tgt_q        <= '0;
      pend         <= 1'b0;
      cmd_status   <= '0;
      cmd_detected <= 1'b0;
    end else begin
      pend <= reg_we && (reg_sel == SEL_CODE);
      if (reg_we && reg_sel == SEL_CODE) code_q <= reg_wdata[7:0];
      if (reg_we && reg_sel == SEL_TGT)  tgt_q  <= reg_wdata[TGT_BITS-1:0];
      if (pend) cmd_status <= {inv_mode, inv_cmd, 2'b00};
      if (pend) cmd_detected <= 1'b1;
      else if (reg_we && reg_sel == SEL_INT && reg_wdata[DONE_CLR_BIT]) cmd_detected <= 1'b0;
    end
  end

  always_comb begin
    cur_st = ST_KEEP;
    for (int i = 0; i < NSLOTS; i++)
      if (tgt_q == TGT_BITS'(i + 1)) cur_st = st_w[i];
    any_en = |en_vec;
    tgt_ok = (tgt_q != '0) && (int'(tgt_q) <= NSLOTS);
  end

  always_comb begin
    inv_cmd   = 1'b0;
    inv_mode  = 1'b0;
    single_go = 1'b0;
    bulk_go   = 1'b0;
    bulk_st   = (f.op == OP_EN_ALL) ? ST_ENABLED : ST_PWRONLY;
    if (pend) begin
      case (f.op)
        OP_SLOT:
          if (!tgt_ok || (cur_st == ST_ENABLED && f.st == ST_PWRONLY)) inv_cmd = 1'b1;
          else single_go = 1'b1;
        OP_MODE:
          if (f.mode != 3'd0) inv_mode = 1'b1;
        OP_PWR_ALL, OP_EN_ALL:
          if (any_en) inv_cmd = 1'b1;
          else bulk_go = 1'b1;
        default: inv_cmd = 1'b1;
      endcase
    end
  end

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    hpc_slot u_slot (
      .clk(clk), .rst_n(rst_n), .occupied(slot_occupied[i]),
      .hit(single_go && (tgt_q == TGT_BITS'(i + 1))),
      .bulk_go(bulk_go), .bulk_st(bulk_st),
      .req_st(f.st), .req_pwr(f.pwr), .req_attn(f.attn),
      .ev_clr(reg_we && (reg_sel == SEL_EVCLR) && reg_wdata[i]),
      .state(st_w[i]), .pwr(pw_w[i]), .attn(at_w[i]),
      .latch_open(slot_latch_open[i]), .presence(slot_presence[2*i +: 2]),
      .ev_presence(slot_ev_presence[i]), .ev_latch(slot_ev_latch[i])
    );
    assign en_vec[i]             = (st_w[i] == ST_ENABLED);
    assign slot_state[2*i +: 2]    = st_w[i];
    assign slot_pwr_ind[2*i +: 2]  = pw_w[i];
    assign slot_attn_ind[2*i +: 2] = at_w[i];
  end

  // R9: status moves only on the cycle a pending command runs
  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> $stable(cmd_status));

  // R10: a running command always leaves the done flag set
  p_done_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> cmd_detected);

  // R3: a rejected command leaves every slot field untouched
  p_reject_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && inv_cmd) |=> ($stable(slot_state) && $stable(slot_pwr_ind) && $stable(slot_attn_ind)));

  // R14: a command runs exactly one cycle after its code write
  p_start_delay_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CODE) |=> pend);
endmodule

// File: tb/hp_slot_ctrl_test.sv
module hp_slot_ctrl_test;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [N-1:0] occ = 4'b0011;
  logic [3:0] cmd_status;
  logic cmd_detected;
  logic [2*N-1:0] st, pw, at, pres;
  logic [N-1:0] lo, evp, evl;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hp_slot_ctrl #(.NSLOTS(N)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .slot_occupied(occ), .cmd_status(cmd_status), .cmd_detected(cmd_detected),
    .slot_state(st), .slot_pwr_ind(pw), .slot_attn_ind(at), .slot_latch_open(lo),
    .slot_presence(pres), .slot_ev_presence(evp), .slot_ev_latch(evl));

  // {code, target, status, slot index, state, power, attention}
  localparam logic [27:0] VEC [17] = '{
    {8'h20, 8'h01, 4'h0, 2'd0, 2'd2, 2'd1, 2'd2},
    {8'h01, 8'h01, 4'h4, 2'd0, 2'd2, 2'd1, 2'd2},
    {8'h08, 8'h02, 4'h0, 2'd1, 2'd2, 2'd2, 2'd3},
    {8'h05, 8'h00, 4'h4, 2'd0, 2'd2, 2'd1, 2'd2},
    {8'h05, 8'h05, 4'h4, 2'd0, 2'd2, 2'd1, 2'd2},
    {8'h41, 8'h01, 4'h8, 2'd0, 2'd2, 2'd1, 2'd2},
    {8'h40, 8'h01, 4'h0, 2'd0, 2'd2, 2'd1, 2'd2},
    {8'h50, 8'h01, 4'h4, 2'd0, 2'd2, 2'd1, 2'd2},
    {8'h48, 8'h01, 4'h4, 2'd2, 2'd3, 2'd3, 2'd3},
    {8'h07, 8'h01, 4'h0, 2'd0, 2'd3, 2'd1, 2'd2},
    {8'h07, 8'h02, 4'h0, 2'd1, 2'd3, 2'd1, 2'd3},
    {8'h49, 8'h01, 4'h0, 2'd0, 2'd2, 2'd1, 2'd2},
    {8'h49, 8'h01, 4'h4, 2'd1, 2'd2, 2'd1, 2'd3},
    {8'h3F, 8'h01, 4'h0, 2'd0, 2'd3, 2'd3, 2'd3},
    {8'h0F, 8'h02, 4'h0, 2'd1, 2'd3, 2'd3, 2'd3},
    {8'h48, 8'h01, 4'h0, 2'd0, 2'd3, 2'd3, 2'd3},
    {8'h10, 8'h21, 4'h0, 2'd0, 2'd3, 2'd3, 2'd1}};

  function automatic string req_of(int i);
    case (i)
      1: return "R4";
      3, 4: return "R3";
      5: return "R5";
      6: return "R9";
      7: return "R8";
      8, 12: return "R6";
      11, 15: return "R7";
      13, 14: return "R11";
      16: return "R12";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic cmd(logic [7:0] code, logic [7:0] tgt);
    wr(2'd1, {24'd0, tgt});
    wr(2'd0, {24'd0, code});
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset values with slots 0,1 occupied
    check("R1 state", {24'd0, st}, {24'd0, 8'hFA});
    check("R1 power", {24'd0, pw}, {24'd0, 8'hF5});
    check("R1 attention", {24'd0, at}, {24'd0, 8'hFF});
    check("R1 latch", {28'd0, lo}, {28'd0, 4'b1100});
    check("R1 presence", {24'd0, pres}, {24'd0, 8'hF0});
    check("R1 status/done", {27'd0, cmd_status, cmd_detected}, 32'd0);

    for (int i = 0; i < 17; i++) begin
      logic [27:0] v;
      int k;
      v = VEC[i];
      cmd(v[27:20], v[19:12]);
      k = int'(v[7:6]);
      check(req_of(i), {28'd0, cmd_status}, {28'd0, v[11:8]});
      check(req_of(i), {30'd0, st[2*k +: 2]}, {30'd0, v[5:4]});
      check(req_of(i), {30'd0, pw[2*k +: 2]}, {30'd0, v[3:2]});
      check(req_of(i), {30'd0, at[2*k +: 2]}, {30'd0, v[1:0]});
    end

    // R11 after both occupied slots were taken to off
    check("R11 latch", {28'd0, lo}, {28'd0, 4'b1111});
    check("R11 presence", {24'd0, pres}, {24'd0, 8'hFF});
    check("R11 ev presence", {28'd0, evp}, {28'd0, 4'b0011});
    check("R11 ev latch", {28'd0, evl}, {28'd0, 4'b0011});

    // R13 per-slot event clear
    wr(2'd3, 32'h1);
    check("R13 ev presence", {28'd0, evp}, {28'd0, 4'b0010});
    check("R13 ev latch", {28'd0, evl}, {28'd0, 4'b0010});

    // R10 done flag
    check("R10 set", {31'd0, cmd_detected}, 32'd1);
    wr(2'd2, 32'h0000_0001);
    check("R10 kept", {31'd0, cmd_detected}, 32'd1);
    wr(2'd2, 32'h0001_0000);
    check("R10 cleared", {31'd0, cmd_detected}, 32'd0);

    // R14 nothing moves before the execution edge
    wr(2'd1, 32'h1);
    wr(2'd0, 32'h20);
    check("R14 attention before", {30'd0, at[1:0]}, 32'd1);
    check("R14 done before", {31'd0, cmd_detected}, 32'd0);
    @(negedge clk);
    check("R14 attention after", {30'd0, at[1:0]}, 32'd2);
    check("R14 done after", {31'd0, cmd_detected}, 32'd1);
    check("R9 busy/latch bits", {30'd0, cmd_status[1:0]}, 32'd0);

    // R7 power-all with closed and open latches
    do_reset();
    cmd(8'h07, 8'h01);
    cmd(8'h07, 8'h02);
    cmd(8'h48, 8'h01);
    check("R7 status", {28'd0, cmd_status}, 32'd0);
    check("R7 slot0 state", {30'd0, st[1:0]}, 32'd1);
    check("R7 slot0 power", {30'd0, pw[1:0]}, 32'd1);
    check("R7 slot2 state", {30'd0, st[5:4]}, 32'd3);
    check("R7 slot2 power", {30'd0, pw[5:4]}, 32'd3);

    finish_run();
  end
endmodule